// File: doc/BRIEF.md
# Programmable Ternary Threshold Gate

This block is a digital threshold gate with several inputs. Each input carries a digit of value 0, 1 or 2 in a 2-bit code, and a plain binary input is the same code restricted to 0 and 1. The gate multiplies each digit by a signed weight that belongs to that input, then adds the products. It compares the sum with programmed thresholds. In ternary mode two thresholds cut the range of sums into three bands, so the output takes one of three levels. In binary mode only the lower threshold is used and the output is 0 or 1.

Weights, the two thresholds and the mode are held in a small register file that is loaded through a single write port. The result is registered. Configuration written in one cycle governs the evaluation made in the next cycle. Setting every weight of three inputs to 1 and the binary threshold to 2 turns the gate into a 3-input majority function.

Top module: `tern_thresh_gate`

## Requirements
- R1: The sum is the total of weight times digit value over all inputs. The digit codes are 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2; code 2'b11 counts as 0. Input i occupies `in_digits[2i+1:2i]`.
- R2: In binary mode (mode bit 0), `level_out` is 2'b01 when sum >= lower threshold and 2'b00 otherwise. It is never 2'b10 or 2'b11.
- R3: In ternary mode with a valid configuration, a sum below the lower threshold gives 2'b00.
- R4: In ternary mode with a valid configuration, a sum at or above the lower threshold and below the upper threshold gives 2'b01. A sum exactly equal to the lower threshold therefore gives 2'b01 whenever lower < upper.
- R5: In ternary mode with a valid configuration, a sum at or above the upper threshold gives 2'b10. A sum exactly equal to the upper threshold gives 2'b10, so lower == upper leaves no middle band.
- R6: In ternary mode, a lower threshold greater than the upper threshold raises `config_error` and forces `level_out` to 2'b00. In binary mode `config_error` stays 0.
- R7: `level_out` shows the result for the inputs sampled at the previous rising edge, using the configuration held before that edge. A write takes effect for the sample taken on the following edge.
- R8: Register map, addressed by `cfg_addr` when `cfg_we` is 1: addresses 0..N_IN-1 hold the weight of input i in `cfg_wdata[W_W-1:0]` (two's complement). Address N_IN holds the lower threshold and N_IN+1 the upper threshold, each as the whole of `cfg_wdata`, signed. Address N_IN+2 holds the mode in `cfg_wdata[0]` (1 = ternary). Writes to any other address change nothing.
- R9: After reset all weights and thresholds are 0, the mode is binary, `level_out` is 2'b00 and `config_error` is 0.
- R10: With weights 1,1,1,0 and a binary threshold of 2, the output is the majority of inputs 0 to 2, each driven with code 0 or 1.
- R11: Extreme weights and digits never overflow the sum. With the defaults the sum spans -64 (all weights -8, all digits 2) to +56 (all weights +7, all digits 2), and thresholds compare against it exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_digits | input | 2*N_IN | Packed 2-bit digit codes, input 0 in the low bits |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | SUM_W | Configuration write data |
| level_out | output | 2 | Registered output level code |
| config_error | output | 1 | Threshold ordering fault in ternary mode |

## Verification
The two actions that can coincide are a configuration write and the sampling of an input pattern on the same rising edge. For that edge the evaluation must use the old weights or thresholds, and the new ones must apply from the next edge. A long phase drives fresh input codes on every cycle and random writes on most cycles, including mode flips and threshold pairs in the wrong order. A reference model in the bench computes each expected level from its own copy of the configuration before it applies that cycle's write. It then compares `level_out` and `config_error` against the model one half-cycle after every edge.

// File: rtl/ttg_pkg.sv
package ttg_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } level_e;

  // Value of a 2-bit digit code; the spare code counts as zero.
  function automatic int digit_value(input logic [1:0] code);
    case (code)
      2'b01:   return 1;
      2'b10:   return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int weighted_term(input int weight, input logic [1:0] code);
    return weight * digit_value(code);
  endfunction

  // Upper band wins on equality, lower threshold is inclusive.
  function automatic level_e band_of(input int s, input int lo, input int hi);
    if (s >= hi)      return LVL_HIGH;
    else if (s >= lo) return LVL_MID;
    else              return LVL_LOW;
  endfunction

  function automatic level_e binary_of(input int s, input int thr);
    return (s >= thr) ? LVL_MID : LVL_LOW;
  endfunction

endpackage

// File: rtl/ttg_cfg_regs.sv
module ttg_cfg_regs #(
  parameter int N_IN  = 4,
  parameter int W_W   = 4,
  parameter int SUM_W = 8,
  parameter int AW    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [SUM_W-1:0]        wdata,
  output logic [N_IN*W_W-1:0]     weights_flat,
  output logic signed [SUM_W-1:0] thr_lo,
  output logic signed [SUM_W-1:0] thr_hi,
  output logic                    tern_mode
);

  localparam logic [AW-1:0] LO_ADDR   = AW'(N_IN);
  localparam logic [AW-1:0] HI_ADDR   = AW'(N_IN + 1);
  localparam logic [AW-1:0] MODE_ADDR = AW'(N_IN + 2);

  // One register per weight slot.
  for (genvar i = 0; i < N_IN; i++) begin : g_weight
    logic [W_W-1:0] w_q;
    wire            hit = we && (addr == AW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)   w_q <= '0;
      else if (hit) w_q <= wdata[W_W-1:0];
    end

    assign weights_flat[i*W_W +: W_W] = w_q;
  end

  wire lo_hit   = we && (addr == LO_ADDR);
  wire hi_hit   = we && (addr == HI_ADDR);
  wire mode_hit = we && (addr == MODE_ADDR);
  wire unmapped = we && (addr > MODE_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_lo    <= '0;
      thr_hi    <= '0;
      tern_mode <= 1'b0;
    end else begin
      if (lo_hit)   thr_lo    <= $signed(wdata);
      if (hi_hit)   thr_hi    <= $signed(wdata);
      if (mode_hit) tern_mode <= wdata[0];
    end
  end

  AST_LO_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    lo_hit |=> thr_lo == $signed($past(wdata))); // R8
  AST_HI_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    hi_hit |=> thr_hi == $signed($past(wdata))); // R8
  AST_MODE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_hit |=> tern_mode == $past(wdata[0])); // R8
  AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |=> ($stable(thr_lo) && $stable(thr_hi) && $stable(tern_mode)
                  && $stable(weights_flat))); // R8

endmodule

// File: rtl/ttg_wsum.sv
module ttg_wsum #(
  parameter int N_IN  = 4,
  parameter int W_W   = 4,
  parameter int SUM_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*N_IN-1:0]       in_digits,
  input  logic [N_IN*W_W-1:0]     weights_flat,
  output logic signed [SUM_W-1:0] sum
);
  import ttg_pkg::*;

  localparam int MAX_MAG = N_IN * 2 * (1 << (W_W - 1));

  int term [N_IN];
  int acc;

  for (genvar i = 0; i < N_IN; i++) begin : g_term
    wire logic [W_W-1:0] w_raw = weights_flat[i*W_W +: W_W];
    wire logic [1:0]     code  = in_digits[2*i +: 2];
    assign term[i] = weighted_term(int'($signed(w_raw)), code);
  end

  always_comb begin
    acc = 0;
    for (int i = 0; i < N_IN; i++) acc += term[i];
  end

  assign sum = acc[SUM_W-1:0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sum) == acc) && (acc <= MAX_MAG) && (acc >= -MAX_MAG)); // R11

endmodule

// File: rtl/ttg_classify.sv
module ttg_classify #(
  parameter int SUM_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SUM_W-1:0] sum,
  input  logic signed [SUM_W-1:0] thr_lo,
  input  logic signed [SUM_W-1:0] thr_hi,
  input  logic                    tern_mode,
  output ttg_pkg::level_e         level_q,
  output logic                    cfg_err
);
  import ttg_pkg::*;

  level_e level_d;
  wire    inverted = thr_lo > thr_hi;

  assign cfg_err = tern_mode && inverted;

  always_comb begin
    if (cfg_err)         level_d = LVL_LOW;
    else if (tern_mode)  level_d = band_of(int'(sum), int'(thr_lo), int'(thr_hi));
    else                 level_d = binary_of(int'(sum), int'(thr_lo));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= LVL_LOW;
    else        level_q <= level_d;
  end

  AST_ERR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> level_q == LVL_LOW); // R6
  AST_BIN_TWO_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !tern_mode |=> (level_q == LVL_LOW || level_q == LVL_MID)); // R2
  AST_UPPER_EDGE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tern_mode && !cfg_err && sum == thr_hi) |=> level_q == LVL_HIGH); // R5
  AST_LOWER_EDGE_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (tern_mode && sum == thr_lo && thr_lo < thr_hi) |=> level_q == LVL_MID); // R4
  AST_BELOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tern_mode && sum < thr_lo) |=> level_q == LVL_LOW); // R3

endmodule

// File: rtl/tern_thresh_gate.sv
module tern_thresh_gate #(
  parameter  int N_IN    = 4,
  parameter  int W_W     = 4,
  localparam int MAX_MAG = N_IN * 2 * (1 << (W_W - 1)),
  localparam int SUM_W   = $clog2(MAX_MAG + 1) + 1,
  localparam int AW      = $clog2(N_IN + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*N_IN-1:0] in_digits,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [SUM_W-1:0]  cfg_wdata,
  output logic [1:0]        level_out,
  output logic              config_error
);
  import ttg_pkg::*;

  logic [N_IN*W_W-1:0]     weights_flat;
  logic signed [SUM_W-1:0] thr_lo;
  logic signed [SUM_W-1:0] thr_hi;
  logic                    tern_mode;
  logic signed [SUM_W-1:0] sum;
  level_e                  level_q;

  ttg_cfg_regs #(.N_IN(N_IN), .W_W(W_W), .SUM_W(SUM_W), .AW(AW)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (cfg_we),
    .addr         (cfg_addr),
    .wdata        (cfg_wdata),
    .weights_flat (weights_flat),
    .thr_lo       (thr_lo),
    .thr_hi       (thr_hi),
    .tern_mode    (tern_mode)
  );

  ttg_wsum #(.N_IN(N_IN), .W_W(W_W), .SUM_W(SUM_W)) u_sum (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_digits    (in_digits),
    .weights_flat (weights_flat),
    .sum          (sum)
  );

  ttg_classify #(.SUM_W(SUM_W)) u_cls (
    .clk       (clk),
    .rst_n     (rst_n),
    .sum       (sum),
    .thr_lo    (thr_lo),
    .thr_hi    (thr_hi),
    .tern_mode (tern_mode),
    .level_q   (level_q),
    .cfg_err   (config_error)
  );

  assign level_out = level_q;

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    level_out != 2'b11); // R2
  AST_BIN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!tern_mode && $past(!tern_mode)) |-> !config_error); // R6

endmodule

// File: tb/tern_thresh_gate_tb_top.sv
module tern_thresh_gate_tb_top;

  localparam int N   = 4;
  localparam int WW  = 4;
  localparam int MM  = N * 2 * (1 << (WW - 1));
  localparam int SW  = $clog2(MM + 1) + 1;
  localparam int AWB = $clog2(N + 3);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2*N-1:0] in_digits = '0;
  logic           cfg_we = 1'b0;
  logic [AWB-1:0] cfg_addr = '0;
  logic [SW-1:0]  cfg_wdata = '0;
  logic [1:0]     level_out;
  logic           config_error;

  always #4ns clk = ~clk;

  tern_thresh_gate #(.N_IN(N), .W_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_digits(in_digits), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .level_out(level_out), .config_error(config_error)
  );

  // Reference state
  int  m_w [N];
  int  m_lo, m_hi;
  bit  m_tern;
  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done = 0;

  function automatic int dval(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b10) return 2;
    return 0;
  endfunction

  function automatic int model_sum();
    int s = 0;
    for (int i = 0; i < N; i++) s += m_w[i] * dval(in_digits[2*i +: 2]);
    return s;
  endfunction

  function automatic bit model_err();
    return m_tern && (m_lo > m_hi);
  endfunction

  function automatic int model_level();
    int s = model_sum();
    if (model_err()) return 0;
    if (!m_tern) return (s >= m_lo) ? 1 : 0;
    if (s >= m_hi) return 2;
    if (s >= m_lo) return 1;
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_w[i] = 0;
    m_lo = 0; m_hi = 0; m_tern = 0;
  endtask

  task automatic model_write();
    if (!cfg_we) return;
    if (int'(cfg_addr) < N) m_w[cfg_addr] = int'($signed(cfg_wdata[WW-1:0]));
    else if (int'(cfg_addr) == N)     m_lo   = int'($signed(cfg_wdata));
    else if (int'(cfg_addr) == N + 1) m_hi   = int'($signed(cfg_wdata));
    else if (int'(cfg_addr) == N + 2) m_tern = cfg_wdata[0];
  endtask

  function automatic string auto_tag(input int lvl);
    if (!m_tern) return "R2";
    if (model_err()) return "R6";
    if (lvl == 0) return "R3";
    if (lvl == 1) return "R4";
    return "R5";
  endfunction

  // One clock: model evaluates with pre-edge config, then applies the write.
  task automatic step(input string tag);
    int    exp_lvl;
    bit    exp_err;
    string t;
    @(posedge clk);
    if (!rst_n) begin
      model_reset();
      exp_lvl = 0;
    end else begin
      exp_lvl = model_level();
      model_write();
    end
    t = (tag == "") ? auto_tag(exp_lvl) : tag;
    @(negedge clk);
    exp_err = rst_n ? model_err() : 1'b0;
    n_checks++;
    if (int'(level_out) != exp_lvl) begin
      n_fails++;
      $display("FAIL %s level_out: actual %0d expected %0d", t, level_out, exp_lvl);
    end
    n_checks++;
    if (config_error != exp_err) begin
      n_fails++;
      $display("FAIL %s config_error: actual %0d expected %0d", t, config_error, exp_err);
    end
  endtask

  task automatic wr(input int addr, input int data, input string tag);
    cfg_we = 1'b1; cfg_addr = AWB'(addr); cfg_wdata = SW'(data);
    step(tag);
    cfg_we = 1'b0;
  endtask

  task automatic set_all(input int w0, input int w1, input int w2, input int w3,
                         input int lo, input int hi, input int tern);
    wr(0, w0, "R8"); wr(1, w1, "R8"); wr(2, w2, "R8"); wr(3, w3, "R8");
    wr(N, lo, "R8"); wr(N + 1, hi, "R8"); wr(N + 2, tern, "R8");
  endtask

  task automatic sweep_all(input string tag);
    for (int p = 0; p < (1 << (2*N)); p++) begin
      in_digits = (2*N)'(p);
      step(tag);
    end
  endtask

  initial begin
    model_reset();
    // R9: reset state
    repeat (3) step("R9");
    rst_n = 1'b1;
    step("R9");

    // R10 / R2: majority of three binary inputs
    set_all(1, 1, 1, 0, 2, 0, 0);
    for (int p = 0; p < 8; p++) begin
      in_digits = {2'b00, 1'b0, p[2], 1'b0, p[1], 1'b0, p[0]};
      step("R10");
    end

    // R1 / R3 / R4 / R5: full code sweep in ternary mode, spare code included
    set_all(3, -2, 1, 2, -2, 5, 1);
    sweep_all("");
    // R5: equal thresholds leave no middle band
    set_all(2, 1, -1, 1, 3, 3, 1);
    sweep_all("");

    // R6: inverted thresholds in ternary, then binary
    set_all(1, 1, 1, 1, 4, 1, 1);
    for (int p = 0; p < 16; p++) begin
      in_digits = (2*N)'(p * 13);
      step("R6");
    end
    wr(N + 2, 0, "R6");
    for (int p = 0; p < 16; p++) begin
      in_digits = (2*N)'(p * 11);
      step("R6");
    end

    // R11: extremes of the sum
    set_all(-8, -8, -8, -8, -64, 56, 1);
    in_digits = 8'b10101010; step("R11"); step("R11");
    set_all(7, 7, 7, 7, -64, 56, 1);
    in_digits = 8'b10101010; step("R11"); step("R11");
    wr(N + 1, 57, "R11"); step("R11");

    // R8: unmapped address changes nothing
    wr(7, 8'h81, "R8");
    in_digits = 8'b01100110; step("R8"); step("R8");

    // R7: writes and input changes on the same edge
    for (int c = 0; c < 2000; c++) begin
      in_digits = (2*N)'($urandom);
      cfg_we    = ($urandom_range(0, 3) != 0);
      cfg_addr  = AWB'($urandom_range(0, 7));
      cfg_wdata = SW'($urandom_range(0, 40)) - SW'(20);
      step("R7");
    end
    cfg_we = 1'b0;

    // R9: reset again mid-run
    rst_n = 1'b0; step("R9"); step("R9");
    rst_n = 1'b1; step("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule